// File: doc/BRIEF.md
# Supply Fault Shutdown Sequencer

This block sits behind the over-voltage and under-voltage comparators of a high-voltage supply monitor. It turns their digital flags into an active-low shutdown output and a reset output that can be linked to shutdown or detached from it. A flag only counts once it has stayed high for more than 50 µs. A counted fault must then last through a programmable assert delay before shutdown drops. Once both flags clear, shutdown stays low for a programmable hold time before it rises again.

Time runs on two tick enables supplied from outside: a microsecond tick for the glitch filter and a millisecond tick for the delay and hold counters. The block therefore works at any clock rate. A warning output is high while a counted fault waits out the assert delay. Two level bits show the present state of the comparators. Two capture bits record which flags were high at the moment shutdown fired, and they stay set until a clear strobe.

Top module: `supply_fault_seq`

## Requirements
- R1: A flag counts as a fault only after it has been high for 51 consecutive `tick_us` pulses, i.e. more than 50 µs. A shorter excursion leaves `warn` low and `shdn_n` high.
- R2: Once a fault counts, `shdn_n` goes low only after the assert delay, measured in `tick_ms` pulses. `dly_code` 000, 001, 010 and 011 select 1200, 1000, 800 and 400 ms.
- R3: After both flags clear, `shdn_n` stays low for the hold time and then returns high. `hold_code` 000, 001, 010 and 011 select 200, 150, 100 and 80 ms.
- R4: Any code with bit 2 set selects the longest entry of its table: 1200 ms for the delay and 200 ms for the hold.
- R5: With `rst_detach` = 0, `sys_rst_n` equals `shdn_n`. With `rst_detach` = 1, `sys_rst_n` stays high.
- R6: `lvl_ov` and `lvl_uv` show `ov_flag` and `uv_flag` one clock later.
- R7: In the cycle that shutdown fires, `cap_ov` and `cap_uv` are set for each flag that is high. They stay set afterwards.
- R8: If the fault clears during the assert delay, the sequence aborts and `shdn_n` never goes low. The next fault starts a fresh full delay.
- R9: If a fault counts again during the hold time, shutdown stays low without a new delay. The full hold time restarts once the fault clears again.
- R10: A one-cycle `cause_clr` pulse clears `cap_ov` and `cap_uv`. A capture in the same cycle takes priority.
- R11: `warn` is high exactly while a counted fault is waiting out the assert delay.
- R12: After reset, `shdn_n` = 1, `sys_rst_n` = 1, `warn` = 0 and all four status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle enable per millisecond |
| tick_us | input | 1 | One-cycle enable per microsecond |
| ov_flag | input | 1 | Over-voltage comparator flag |
| uv_flag | input | 1 | Under-voltage comparator flag |
| dly_code | input | 3 | Assert delay code |
| hold_code | input | 3 | Release hold code |
| rst_detach | input | 1 | 1 = shutdown does not drive the reset output |
| cause_clr | input | 1 | Clears the capture bits |
| shdn_n | output | 1 | Active-low shutdown |
| sys_rst_n | output | 1 | Active-low reset output |
| warn | output | 1 | Counted fault waiting for shutdown |
| lvl_ov | output | 1 | Present over-voltage flag |
| lvl_uv | output | 1 | Present under-voltage flag |
| cap_ov | output | 1 | Over-voltage was present when shutdown fired |
| cap_uv | output | 1 | Under-voltage was present when shutdown fired |

## Verification
A flag held by the bench, with `tick_us` high every cycle, counts as a fault on the 51st clock edge. The state moves to the delay on the next edge, so `warn` is sampled several cycles later and a 50-cycle pulse is checked as having no effect. The delay and hold results are due a whole number of `tick_ms` periods (8 clocks) after entry, and the tick phase is not known in advance. Each timed check therefore samples two ticks before the due point, where the old value must still hold, and two ticks after it, where the new value must be present. Level bits are sampled two cycles after a flag changes, and capture and clear bits one cycle after their cause, all on falling edges.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam int MAX_MS = 1200;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DELAY,
    ST_ASSERT,
    ST_HOLD
  } seq_state_t;

  function automatic int delay_ms(input logic [2:0] code);
    case (code)
      3'd1:    delay_ms = 1000;
      3'd2:    delay_ms = 800;
      3'd3:    delay_ms = 400;
      default: delay_ms = 1200;
    endcase
  endfunction

  function automatic int hold_ms(input logic [2:0] code);
    case (code)
      3'd1:    hold_ms = 150;
      3'd2:    hold_ms = 100;
      3'd3:    hold_ms = 80;
      default: hold_ms = 200;
    endcase
  endfunction
endpackage

// File: rtl/sfs_glitch_filter.sv
module sfs_glitch_filter #(
  parameter int GLITCH_US = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_us,
  input  logic raw,
  output logic qual
);
  localparam int RUN   = GLITCH_US + 1;
  localparam int CNT_W = $clog2(RUN + 1);
  localparam logic [CNT_W-1:0] RUN_C = CNT_W'(RUN);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (!raw)                     cnt <= '0;
    else if (tick_us && cnt != RUN_C)  cnt <= cnt + 1'b1;
  end

  assign qual = raw && (cnt == RUN_C);

  AST_QUAL_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qual) |-> ($past(raw) && $past(cnt) != '0)); // R1
endmodule

// File: rtl/sfs_seq_fsm.sv
module sfs_seq_fsm
  import sfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       fault_q,
  input  logic [2:0] dly_code,
  input  logic [2:0] hold_code,
  output logic       fire,
  output logic       shut,
  output logic       pending
);
  localparam int CNT_W = $clog2(MAX_MS + 1);

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] dly_last, hold_last;

  assign dly_last  = CNT_W'(delay_ms(dly_code) - 1);
  assign hold_last = CNT_W'(hold_ms(hold_code) - 1);
  assign fire      = (state_q == ST_DELAY) && fault_q && tick_ms && (cnt == dly_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          cnt <= '0;
          if (fault_q) state_q <= ST_DELAY;
        end
        ST_DELAY: begin
          if (!fault_q) begin
            state_q <= ST_IDLE;
            cnt     <= '0;
          end else if (fire) begin
            state_q <= ST_ASSERT;
            cnt     <= '0;
          end else if (tick_ms) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ASSERT: begin
          cnt <= '0;
          if (!fault_q) state_q <= ST_HOLD;
        end
        ST_HOLD: begin
          if (fault_q) begin
            state_q <= ST_ASSERT;
            cnt     <= '0;
          end else if (tick_ms) begin
            if (cnt == hold_last) begin
              state_q <= ST_IDLE;
              cnt     <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign shut    = (state_q == ST_ASSERT) || (state_q == ST_HOLD);
  assign pending = (state_q == ST_DELAY);

  AST_NO_SKIP_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |=> (state_q != ST_ASSERT)); // R2
  AST_ABORT_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !fault_q) |=> !shut); // R8
  AST_HOLD_REFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_HOLD) && fault_q) |=> (state_q == ST_ASSERT)); // R9
endmodule

// File: rtl/supply_fault_seq.sv
module supply_fault_seq #(
  parameter int GLITCH_US = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       tick_us,
  input  logic       ov_flag,
  input  logic       uv_flag,
  input  logic [2:0] dly_code,
  input  logic [2:0] hold_code,
  input  logic       rst_detach,
  input  logic       cause_clr,
  output logic       shdn_n,
  output logic       sys_rst_n,
  output logic       warn,
  output logic       lvl_ov,
  output logic       lvl_uv,
  output logic       cap_ov,
  output logic       cap_uv
);
  localparam int NFLAG = 2;

  logic [NFLAG-1:0] raw, qual;
  logic             fire, shut, pending;

  assign raw = {ov_flag, uv_flag};

  for (genvar g = 0; g < NFLAG; g++) begin : g_filt
    sfs_glitch_filter #(.GLITCH_US(GLITCH_US)) i_filt (
      .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .raw(raw[g]), .qual(qual[g])
    );
  end

  sfs_seq_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .fault_q(|qual),
    .dly_code(dly_code), .hold_code(hold_code),
    .fire(fire), .shut(shut), .pending(pending)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_ov <= 1'b0;
      lvl_uv <= 1'b0;
      cap_ov <= 1'b0;
      cap_uv <= 1'b0;
    end else begin
      lvl_ov <= ov_flag;
      lvl_uv <= uv_flag;
      if (fire) begin
        cap_ov <= cap_ov | ov_flag;
        cap_uv <= cap_uv | uv_flag;
      end else if (cause_clr) begin
        cap_ov <= 1'b0;
        cap_uv <= 1'b0;
      end
    end
  end

  assign shdn_n    = !shut;
  assign sys_rst_n = rst_detach ? 1'b1 : !shut;
  assign warn      = pending;

  AST_CAUSE_AT_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shdn_n) |-> (cap_ov || cap_uv)); // R7
  AST_WARN_BEFORE_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shdn_n) |-> $past(warn)); // R11
endmodule

// File: tb/test_supply_fault_seq.sv
module test_supply_fault_seq;
  localparam int TP = 8;  // clocks per millisecond tick

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_ms = 1'b0, tick_us = 1'b1;
  logic ov_flag = 1'b0, uv_flag = 1'b0;
  logic [2:0] dly_code = 3'd3, hold_code = 3'd3;
  logic rst_detach = 1'b0, cause_clr = 1'b0;
  logic shdn_n, sys_rst_n, warn, lvl_ov, lvl_uv, cap_ov, cap_uv;
  int n_chk = 0, n_fail = 0;
  int mcnt = 0;

  always #5 clk = ~clk;

  supply_fault_seq i_supply_fault_seq (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .tick_us(tick_us),
    .ov_flag(ov_flag), .uv_flag(uv_flag), .dly_code(dly_code), .hold_code(hold_code),
    .rst_detach(rst_detach), .cause_clr(cause_clr), .shdn_n(shdn_n), .sys_rst_n(sys_rst_n),
    .warn(warn), .lvl_ov(lvl_ov), .lvl_uv(lvl_uv), .cap_ov(cap_ov), .cap_uv(cap_uv)
  );

  always @(negedge clk) begin
    mcnt    <= (mcnt == TP - 1) ? 0 : mcnt + 1;
    tick_ms <= (mcnt == TP - 1);
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R12", "shdn_n", shdn_n, 1);
    check("R12", "sys_rst_n", sys_rst_n, 1);
    check("R12", "warn", warn, 0);
    check("R12", "status", {lvl_ov, lvl_uv, cap_ov, cap_uv}, 0);
  endtask

  task automatic t_glitch();
    ov_flag = 1'b1; wcyc(50); ov_flag = 1'b0;
    wcyc(5);
    check("R1", "warn after 50us pulse", warn, 0);
    wcyc(450 * TP);
    check("R1", "shdn_n after 50us pulse", shdn_n, 1);
  endtask

  task automatic t_abort();
    dly_code = 3'd3;
    ov_flag = 1'b1; wcyc(56);
    check("R11", "warn while pending", warn, 1);
    check("R1", "warn after 56us", warn, 1);
    wcyc(100 * TP);
    ov_flag = 1'b0; wcyc(2);
    check("R11", "warn after abort", warn, 0);
    wcyc(405 * TP);
    check("R8", "shdn_n after abort", shdn_n, 1);
    check("R7", "no capture after abort", {cap_ov, cap_uv}, 0);
  endtask

  task automatic t_delay_hold(input logic [2:0] dc, input logic [2:0] hc,
                              input int dms, input int hms, input string dreq, input string hreq);
    dly_code = dc; hold_code = hc;
    uv_flag = 1'b1;
    wcyc(52 + (dms - 2) * TP);
    check(dreq, "shdn_n before delay", shdn_n, 1);
    check("R5", "sys_rst_n before delay", sys_rst_n, 1);
    check("R6", "lvl_uv", lvl_uv, 1);
    check("R6", "lvl_ov", lvl_ov, 0);
    wcyc(4 * TP + 8);
    check(dreq, "shdn_n after delay", shdn_n, 0);
    check("R5", "sys_rst_n follows", sys_rst_n, 0);
    check("R11", "warn once shut", warn, 0);
    check("R7", "cap_uv", cap_uv, 1);
    check("R7", "cap_ov", cap_ov, 0);
    uv_flag = 1'b0;
    wcyc(2);
    check("R6", "lvl_uv cleared", lvl_uv, 0);
    wcyc((hms - 2) * TP);
    check(hreq, "shdn_n inside hold", shdn_n, 0);
    wcyc(4 * TP);
    check(hreq, "shdn_n after hold", shdn_n, 1);
    check("R7", "cap_uv kept", cap_uv, 1);
  endtask

  task automatic t_clear();
    cause_clr = 1'b1; wcyc(1); cause_clr = 1'b0;
    check("R10", "caps after clear", {cap_ov, cap_uv}, 0);
  endtask

  task automatic t_refault();
    dly_code = 3'd1; hold_code = 3'd1;
    ov_flag = 1'b1;
    wcyc(52 + 998 * TP);
    check("R2", "shdn_n before 1000ms", shdn_n, 1);
    wcyc(4 * TP + 8);
    check("R2", "shdn_n after 1000ms", shdn_n, 0);
    check("R7", "cap_ov", cap_ov, 1);
    ov_flag = 1'b0; wcyc(50 * TP);
    ov_flag = 1'b1; wcyc(60 + 200 * TP);
    check("R9", "shdn_n after refault", shdn_n, 0);
    ov_flag = 1'b0;
    wcyc(148 * TP);
    check("R9", "shdn_n hold restarted", shdn_n, 0);
    wcyc(4 * TP);
    check("R3", "shdn_n after 150ms", shdn_n, 1);
  endtask

  task automatic t_detach();
    rst_detach = 1'b1; dly_code = 3'd2; hold_code = 3'd2;
    ov_flag = 1'b1; uv_flag = 1'b1;
    wcyc(52 + 798 * TP);
    check("R2", "shdn_n before 800ms", shdn_n, 1);
    wcyc(4 * TP + 8);
    check("R2", "shdn_n after 800ms", shdn_n, 0);
    check("R5", "sys_rst_n detached", sys_rst_n, 1);
    check("R7", "both caps", {cap_ov, cap_uv}, 3);
    ov_flag = 1'b0; uv_flag = 1'b0;
    wcyc(98 * TP);
    check("R3", "shdn_n inside 100ms", shdn_n, 0);
    wcyc(4 * TP);
    check("R3", "shdn_n after 100ms", shdn_n, 1);
    rst_detach = 1'b0;
  endtask

  initial begin
    wcyc(3);
    t_reset();
    rst_n = 1'b1; wcyc(2);
    t_reset();
    t_glitch();
    t_abort();
    t_delay_hold(3'd3, 3'd3, 400, 80, "R2", "R3");
    t_clear();
    t_delay_hold(3'd6, 3'd5, 1200, 200, "R4", "R4");
    t_delay_hold(3'd0, 3'd0, 1200, 200, "R2", "R3");
    t_clear();
    t_refault();
    t_detach();
    t_clear();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule